// File: doc/BRIEF.md
# Serial Flash Slave Interface with Dual-Output Read

This block is the device side of a small serial flash memory. Its inputs are the serial clock, chip select, pause, write-protect and serial data pins. It oversamples all of them with the system clock. It accepts an 8-bit opcode and then a 24-bit address, both most significant bit first. For reads it streams bytes back, either on one output pin or on two pins at once. For writes it passes program and erase requests to a byte array held in registers. Each request is first checked against a write-enable latch and a write-protect policy.

The host can idle the serial clock low or high, and nothing has to be configured for either case. A low pause input freezes a transfer at its current bit, and the transfer continues from that bit once the pause ends. The block-protect bits come in from an external status register. When write-protect is low, these bits mark a range of top sectors as read-only. Six opcodes are decoded: READ 0x03, FAST 0x0B (8 dummy clocks), DUAL 0x3B (8 dummy clocks, two bits per clock), WREN 0x06, PROG 0x02 and ERASE 0x20.

FSM states: ST_IDLE (select high), ST_CMD (opcode bits), ST_ADDR (address bits), ST_DUMMY (8 wait clocks), ST_READ (data out), ST_PROG (data in), ST_DONE (ignore until deselect). Transitions: IDLE→CMD when select falls. CMD→ADDR on the 8th bit of a read, program or erase opcode. CMD→DONE on WREN or an unknown opcode. ADDR→READ for READ. ADDR→DUMMY for FAST or DUAL. ADDR→PROG for an accepted program. ADDR→DONE for an erase or a rejected program. DUMMY→READ after 8 clocks. Any state→IDLE when select rises.

Top module: `spi_flash_front`

## Requirements
- R1: Opcode, address and program data bits are captured on rising serial-clock edges. Read data changes on falling edges. Both hold whether the clock rests low or high while deselected.
- R2: While cs_n is high, both output enables are low and serial activity has no effect. Raising cs_n part-way through an opcode discards it.
- R3: READ (0x03) returns bytes on so_out MSB first, starting at the address, on the falling edge after the last address bit. The address increments after each byte and wraps from the top of the array to 0. Address bits above the array size are ignored.
- R4: FAST (0x0B) behaves like READ, except that 8 dummy clocks follow the address before data starts.
- R5: DUAL (0x3B) inserts 8 dummy clocks and then drives two bits per falling edge, with sio_oe high. so_out carries bits 7,5,3,1 and sio_out carries bits 6,4,2,0.
- R6: While hold_n is low, serial-clock edges are ignored and both output enables are low. After release, the transfer continues at the next bit.
- R7: WREN (0x06) sets wel on its 8th bit. A program or erase issued while wel is 0 leaves the array unchanged.
- R8: In PROG (0x02), each complete data byte is stored as old AND new. Bytes go to page base plus an offset that wraps within PAGE_BYTES. wel clears when cs_n rises.
- R9: ERASE (0x20) sets every byte of the SECTOR_BYTES sector holding the address to 0xFF, and clears wel.
- R10: A program or erase is blocked when wp_n is low and the target sector is among the top N sectors. N is 0 for bp_bits=0, otherwise min(sector count, 2^(bp_bits-1)). A blocked request changes nothing, sets prot_flag and clears wel. The next WREN clears prot_flag. When wp_n is high, nothing is ever blocked.
- R11: After reset, both output enables, wel and prot_flag are 0, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write-protect enable |
| sio_in | input | 1 | Serial data into the block |
| bp_bits | input | 3 | Block-protect level from the status register |
| so_out | output | 1 | Serial data out (odd bits in dual mode) |
| so_oe | output | 1 | Output enable for so_out |
| sio_out | output | 1 | Second data output (even bits in dual mode) |
| sio_oe | output | 1 | Output enable for sio_out |
| wel | output | 1 | Write-enable latch |
| prot_flag | output | 1 | Set when a write was blocked by protection |

## Verification
The bench builds the block with a 256-byte array, 16-byte pages and 64-byte sectors. These small sizes put the page wrap, the top-of-array read wrap and every block-protect boundary (one, two or all four sectors) within a few bytes of traffic. With a serial half-period of six system clocks, the oversampling latency shows up in every sampled bit. Both clock idle levels are exercised, including a pause in the middle of a byte.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_READ,
        ST_PROG,
        ST_DONE
    } flash_st_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_READ,
        K_FAST,
        K_DUAL,
        K_PROG,
        K_ERASE
    } flash_kind_e;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_DUAL  = 8'h3B;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h20;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int          WIDTH   = 5,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];

endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard #(
    parameter int MEM_BYTES    = 256,
    parameter int SECTOR_BYTES = 64,
    localparam int AW     = $clog2(MEM_BYTES),
    localparam int SW     = $clog2(SECTOR_BYTES),
    localparam int SECT_W = AW - SW,
    localparam int NSECT  = MEM_BYTES / SECTOR_BYTES
) (
    input  logic              wp_n,
    input  logic [2:0]        bp,
    input  logic [SECT_W-1:0] sect,
    output logic              blocked
);

    // R10: top min(NSECT, 2^(bp-1)) sectors are read-only while wp_n is low
    int prot_cnt;

    always_comb begin
        if (bp == 3'd0) prot_cnt = 0;
        else            prot_cnt = 1 << (int'(bp) - 1);
        if (prot_cnt > NSECT) prot_cnt = NSECT;
        blocked = !wp_n && (prot_cnt != 0) && (int'(sect) >= NSECT - prot_cnt);
    end

endmodule

// File: rtl/spi_byte_array.sv
module spi_byte_array #(
    parameter int MEM_BYTES    = 256,
    parameter int SECTOR_BYTES = 64,
    localparam int AW     = $clog2(MEM_BYTES),
    localparam int SW     = $clog2(SECTOR_BYTES),
    localparam int SECT_W = AW - SW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              er_en,
    input  logic [SECT_W-1:0] er_sect
);

    logic [7:0] cells [MEM_BYTES];

    // R8 programming only clears bits; R9 erase sets a whole sector; R11 reset to erased
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) cells[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (er_en && (int'(er_sect) == i / SECTOR_BYTES))
                    cells[i] <= 8'hFF;
                else if (wr_en && (int'(wr_addr) == i))
                    cells[i] <= cells[i] & wr_data;
            end
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
    import spi_flash_pkg::*;
#(
    parameter int MEM_BYTES    = 256,
    parameter int PAGE_BYTES   = 16,
    parameter int SECTOR_BYTES = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       hold_n,
    input  logic       wp_n,
    input  logic       sio_in,
    input  logic [2:0] bp_bits,
    output logic       so_out,
    output logic       so_oe,
    output logic       sio_out,
    output logic       sio_oe,
    output logic       wel,
    output logic       prot_flag
);

    localparam int AW     = $clog2(MEM_BYTES);
    localparam int SW     = $clog2(SECTOR_BYTES);
    localparam int SECT_W = AW - SW;
    localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

    // ---------------- input sampling ----------------
    logic [4:0] pins_raw, pins_syn;
    logic sck_s, cs_s, hold_s, wp_s, sio_s;

    assign pins_raw = {sck, cs_n, hold_n, wp_n, sio_in};

    spi_in_sync #(
        .WIDTH  (5),
        .STAGES (SYNC_STAGES),
        .RST_VAL(5'b0_1_1_1_0)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pins_raw),
        .d_out(pins_syn)
    );

    assign {sck_s, cs_s, hold_s, wp_s, sio_s} = pins_syn;

    // ---------------- state and datapath registers ----------------
    flash_st_e   st_q, st_d;
    flash_kind_e kind_q;
    logic        sck_prev;
    logic [4:0]  bitcnt;
    logic [7:0]  sh_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] pp_ptr;
    logic        wel_q, prot_q;
    logic        wr_en, er_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]  wr_data;

    logic        active, rise, fall;
    logic [7:0]  byte_next;
    logic [AW-1:0] addr_next;
    logic        blocked;

    // R1 edge detection is the same for either clock idle level; R6 pause masks edges
    assign active    = !cs_s && hold_s;
    assign rise      = active && sck_s && !sck_prev;
    assign fall      = active && !sck_s && sck_prev;
    assign byte_next = {sh_q[6:0], sio_s};
    assign addr_next = {addr_q[AW-2:0], sio_s};

    spi_wp_guard #(
        .MEM_BYTES   (MEM_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_guard (
        .wp_n   (wp_s),
        .bp     (bp_bits),
        .sect   (addr_next[AW-1:SW]),
        .blocked(blocked)
    );

    // ---------------- backing array ----------------
    logic [AW-1:0] rd_ptr;
    logic [7:0]    rd_data;

    spi_byte_array #(
        .MEM_BYTES   (MEM_BYTES),
        .SECTOR_BYTES(SECTOR_BYTES)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(rd_ptr),
        .rd_data(rd_data),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .er_en  (er_en),
        .er_sect(addr_q[AW-1:SW])
    );

    // ---------------- next-state logic ----------------
    always_comb begin
        st_d = st_q;
        if (cs_s) begin
            st_d = ST_IDLE;                       // R2 deselect aborts
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_CMD;
                ST_CMD: begin
                    if (rise && bitcnt == 5'd7) begin
                        case (byte_next)
                            OP_READ, OP_FAST, OP_DUAL, OP_PROG, OP_ERASE: st_d = ST_ADDR;
                            default:                                      st_d = ST_DONE;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (rise && bitcnt == 5'd23) begin
                        case (kind_q)
                            K_READ:         st_d = ST_READ;
                            K_FAST, K_DUAL: st_d = ST_DUMMY;
                            K_PROG:         st_d = (wel_q && !blocked) ? ST_PROG : ST_DONE;
                            default:        st_d = ST_DONE;
                        endcase
                    end
                end
                ST_DUMMY: if (rise && bitcnt == 5'd7) st_d = ST_READ;   // R4 R5
                ST_READ:  st_d = ST_READ;
                ST_PROG:  st_d = ST_PROG;
                ST_DONE:  st_d = ST_DONE;
            endcase
        end
    end

    // ---------------- state register and input-side datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            kind_q   <= K_NONE;
            sck_prev <= 1'b0;
            bitcnt   <= '0;
            sh_q     <= '0;
            addr_q   <= '0;
            pp_ptr   <= '0;
            wel_q    <= 1'b0;
            prot_q   <= 1'b0;
            wr_en    <= 1'b0;
            er_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            st_q     <= st_d;
            sck_prev <= sck_s;
            wr_en    <= 1'b0;
            er_en    <= 1'b0;
            if (cs_s) begin
                bitcnt <= '0;
                if (st_q == ST_PROG) wel_q <= 1'b0;        // R8
            end else if (rise) begin
                bitcnt <= bitcnt + 5'd1;
                case (st_q)
                    ST_CMD: begin
                        sh_q <= byte_next;
                        if (bitcnt == 5'd7) begin
                            bitcnt <= '0;
                            case (byte_next)
                                OP_READ:  kind_q <= K_READ;
                                OP_FAST:  kind_q <= K_FAST;
                                OP_DUAL:  kind_q <= K_DUAL;
                                OP_PROG:  kind_q <= K_PROG;
                                OP_ERASE: kind_q <= K_ERASE;
                                default:  kind_q <= K_NONE;
                            endcase
                            if (byte_next == OP_WREN) begin   // R7
                                wel_q  <= 1'b1;
                                prot_q <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR: begin
                        addr_q <= addr_next;
                        if (bitcnt == 5'd23) begin
                            bitcnt <= '0;
                            if (kind_q == K_PROG || kind_q == K_ERASE) begin
                                if (!wel_q) begin
                                    wel_q <= 1'b0;             // R7
                                end else if (blocked) begin
                                    prot_q <= 1'b1;            // R10
                                    wel_q  <= 1'b0;
                                end else if (kind_q == K_ERASE) begin
                                    er_en <= 1'b1;             // R9
                                    wel_q <= 1'b0;
                                end else begin
                                    pp_ptr <= addr_next;
                                end
                            end
                        end
                    end
                    ST_DUMMY: if (bitcnt == 5'd7) bitcnt <= '0;
                    ST_PROG: begin
                        sh_q <= byte_next;
                        if (bitcnt[2:0] == 3'd7) begin
                            wr_en   <= 1'b1;
                            wr_addr <= pp_ptr;
                            wr_data <= byte_next;
                            pp_ptr  <= (pp_ptr & ~PMASK) | ((pp_ptr + AW'(1)) & PMASK);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // ---------------- output shifter ----------------
    logic       dual;
    logic [7:0] osh;
    logic [2:0] ocnt;

    assign dual = (kind_q == K_DUAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_out  <= 1'b0;
            sio_out <= 1'b0;
            osh     <= '0;
            ocnt    <= '0;
            rd_ptr  <= '0;
        end else if (cs_s) begin
            ocnt <= '0;
        end else if (st_q == ST_ADDR && rise && bitcnt == 5'd23) begin
            rd_ptr <= addr_next;                          // R3
            ocnt   <= '0;
        end else if (st_q == ST_READ && fall) begin       // R1 data on falling edges
            if (ocnt == 3'd0) begin
                so_out  <= rd_data[7];
                sio_out <= rd_data[6];
                osh     <= dual ? {rd_data[5:0], 2'b00} : {rd_data[6:0], 1'b0};
                ocnt    <= dual ? 3'd3 : 3'd7;
                rd_ptr  <= rd_ptr + AW'(1);               // R3 wraps at array top
            end else begin
                so_out  <= osh[7];
                sio_out <= osh[6];
                osh     <= dual ? {osh[5:0], 2'b00} : {osh[6:0], 1'b0};
                ocnt    <= ocnt - 3'd1;
            end
        end
    end

    assign so_oe     = (st_q == ST_READ) && hold_s;       // R6
    assign sio_oe    = so_oe && dual;                     // R5
    assign wel       = wel_q;
    assign prot_flag = prot_q;

endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       hold_s,
    input logic       so_oe,
    input logic       sio_oe,
    input logic       wel,
    input logic       prot_flag,
    input logic       wr_en,
    input logic       er_en,
    input logic [4:0] bitcnt
);

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (!so_oe && !sio_oe)); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !cs_s) |=> $stable(bitcnt)); // R6

    AST_DUAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sio_oe |-> so_oe); // R5

    AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wel); // R8

    AST_ERASE_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        er_en |-> !wel); // R9

    AST_BLOCK_DROPS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_flag) |-> !wel); // R10

endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .hold_s   (hold_s),
    .so_oe    (so_oe),
    .sio_oe   (sio_oe),
    .wel      (wel),
    .prot_flag(prot_flag),
    .wr_en    (wr_en),
    .er_en    (er_en),
    .bitcnt   (bitcnt)
);

// File: tb/tb_spi_flash_front.sv
module tb_spi_flash_front;

    localparam int MEMB  = 256;
    localparam int PAGEB = 16;
    localparam int SECB  = 64;
    localparam int H     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, wp_n = 1'b1, sio_in = 1'b0;
    logic [2:0] bp = 3'd0;
    logic so_out, so_oe, sio_out, sio_oe, wel, prot_flag;

    always #5 clk = ~clk;

    spi_flash_front #(
        .MEM_BYTES(MEMB), .PAGE_BYTES(PAGEB), .SECTOR_BYTES(SECB), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
        .wp_n(wp_n), .sio_in(sio_in), .bp_bits(bp),
        .so_out(so_out), .so_oe(so_oe), .sio_out(sio_out), .sio_oe(sio_oe),
        .wel(wel), .prot_flag(prot_flag)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  mode3  = 1'b0;
    int  idle_cnt = 0;
    logic [7:0] mm [MEMB];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // model compared every clock: deselected for a while -> both drivers off (R2)
    always @(negedge clk) begin
        if (!rst_n || !cs_n) idle_cnt = 0;
        else idle_cnt++;
        if (!done && idle_cnt >= 5)
            chk(!so_oe && !sio_oe, "R2 outputs off while deselected", {so_oe, sio_oe}, 0);
    end

    task automatic t_begin();
        sck = mode3;
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic t_end();
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(H);
        end
        cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sck = 1'b0; sio_in = b[i];
            wait_clk(H);
            sck = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic send_addr(input logic [23:0] a);
        send_bits(a[23:16], 8);
        send_bits(a[15:8], 8);
        send_bits(a[7:0], 8);
    endtask

    task automatic recv(input bit dual_m, input bit do_hold, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < (dual_m ? 4 : 8); i++) begin
            sck = 1'b0;
            wait_clk(H);
            if (dual_m) begin
                b = {b[5:0], so_out, sio_out};
                chk(so_oe && sio_oe, "R5 both pins driven", {so_oe, sio_oe}, 3);
            end else begin
                b = {b[6:0], so_out};
                chk(so_oe && !sio_oe, "R3 single pin driven", {so_oe, sio_oe}, 2);
            end
            if (do_hold && i == 2) begin
                hold_n = 1'b0;
                wait_clk(4);
                chk(!so_oe && !sio_oe, "R6 drivers off during pause", {so_oe, sio_oe}, 0);
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; wait_clk(H);
                    sck = 1'b0; wait_clk(H);
                end
                hold_n = 1'b1;
                wait_clk(4);
            end
            sck = 1'b1;
            wait_clk(H);
        end
    endtask

    task automatic do_wren();
        t_begin(); send_bits(8'h06, 8); t_end();
    endtask

    task automatic do_read(input logic [7:0] op, input logic [23:0] a, input int n,
                           input int hold_at, input string tag);
        logic [7:0] got;
        int idx;
        t_begin();
        send_bits(op, 8);
        send_addr(a);
        if (op != 8'h03) send_bits(8'h00, 8);
        for (int k = 0; k < n; k++) begin
            recv(op == 8'h3B, k == hold_at, got);
            idx = (int'(a) + k) % MEMB;
            chk(got == mm[idx], tag, got, mm[idx]);
        end
        t_end();
    endtask

    task automatic do_prog(input logic [23:0] a, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n, input bit ok);
        logic [7:0] d [3];
        int base, off;
        d[0] = d0; d[1] = d1; d[2] = d2;
        t_begin();
        send_bits(8'h02, 8);
        send_addr(a);
        for (int k = 0; k < n; k++) send_bits(d[k], 8);
        t_end();
        if (ok) begin
            base = (int'(a) % MEMB) / PAGEB * PAGEB;
            off  = int'(a) % PAGEB;
            for (int k = 0; k < n; k++)
                mm[base + (off + k) % PAGEB] = mm[base + (off + k) % PAGEB] & d[k];
        end
    endtask

    task automatic do_erase(input logic [23:0] a, input bit ok);
        int base;
        t_begin();
        send_bits(8'h20, 8);
        send_addr(a);
        t_end();
        if (ok) begin
            base = (int'(a) % MEMB) / SECB * SECB;
            for (int k = 0; k < SECB; k++) mm[base + k] = 8'hFF;
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        for (int i = 0; i < MEMB; i++) mm[i] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);

        // R11 reset state
        chk(!so_oe && !sio_oe, "R11 enables low after reset", {so_oe, sio_oe}, 0);
        chk(!wel, "R11 wel low after reset", wel, 0);
        chk(!prot_flag, "R11 prot_flag low after reset", prot_flag, 0);
        do_read(8'h03, 24'h000010, 2, -1, "R11 erased content");

        // R7 / R8 program with clock idling low
        mode3 = 1'b0;
        do_wren();
        chk(wel, "R7 wel set by write enable", wel, 1);
        do_prog(24'h000005, 8'hA5, 8'h3C, 8'h00, 2, 1'b1);
        chk(!wel, "R8 wel cleared after program", wel, 0);

        // R1 clock idling high
        mode3 = 1'b1;
        do_read(8'h03, 24'h000005, 3, -1, "R1 mode3 read");
        do_wren();
        do_prog(24'h00001E, 8'h5A, 8'hF0, 8'h0F, 3, 1'b1);
        do_read(8'h03, 24'h000010, 1, -1, "R8 page offset wrap");
        do_read(8'h03, 24'h00001E, 2, -1, "R8 page programmed");

        // R3 wrap and high address bits
        mode3 = 1'b0;
        do_wren();
        do_prog(24'h000000, 8'h11, 8'h00, 8'h00, 1, 1'b1);
        do_read(8'h03, 24'h0000FF, 2, -1, "R3 array top wrap");
        do_read(8'h03, 24'h010005, 1, -1, "R3 upper address bits ignored");

        // R4 / R5
        mode3 = 1'b1;
        do_read(8'h0B, 24'h000005, 2, -1, "R4 fast read");
        mode3 = 1'b0;
        do_read(8'h3B, 24'h00001E, 3, -1, "R5 dual read");
        mode3 = 1'b1;
        do_read(8'h3B, 24'h000005, 2, -1, "R5 dual read mode3");

        // R7 program without enable
        mode3 = 1'b0;
        do_prog(24'h000040, 8'h00, 8'h00, 8'h00, 1, 1'b0);
        chk(!wel, "R7 wel stays low", wel, 0);
        do_read(8'h03, 24'h000040, 1, -1, "R7 program ignored without enable");

        // R2 partial opcode and deselected activity
        t_begin(); send_bits(8'h06, 7); t_end();
        chk(!wel, "R2 partial opcode discarded", wel, 0);
        sck = 1'b0; wait_clk(2);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; sio_in = (8'h06 >> i) & 1; wait_clk(H);
            sck = 1'b1; wait_clk(H);
        end
        chk(!wel, "R2 deselected clocks ignored", wel, 0);
        do_wren();
        chk(wel, "R2 recovers after abort", wel, 1);
        do_prog(24'h000041, 8'h77, 8'h00, 8'h00, 1, 1'b1);

        // R9 erase
        do_wren();
        do_erase(24'h000012, 1'b1);
        chk(!wel, "R9 wel cleared after erase", wel, 0);
        do_read(8'h03, 24'h000005, 1, -1, "R9 sector erased");
        do_read(8'h03, 24'h00001E, 2, -1, "R9 sector erased upper");
        do_read(8'h03, 24'h000041, 1, -1, "R9 other sector kept");

        // R10 protection
        wp_n = 1'b0; bp = 3'd1;
        do_wren();
        do_prog(24'h0000C4, 8'h00, 8'h00, 8'h00, 1, 1'b0);
        chk(prot_flag, "R10 blocked program flagged", prot_flag, 1);
        chk(!wel, "R10 wel cleared on block", wel, 0);
        do_read(8'h03, 24'h0000C4, 1, -1, "R10 protected byte unchanged");
        do_wren();
        chk(!prot_flag, "R10 flag cleared by write enable", prot_flag, 0);
        do_prog(24'h000080, 8'h12, 8'h00, 8'h00, 1, 1'b1);
        do_read(8'h03, 24'h000080, 1, -1, "R10 unprotected sector programmed");
        wp_n = 1'b1;
        do_wren();
        do_prog(24'h0000C4, 8'h34, 8'h00, 8'h00, 1, 1'b1);
        chk(!prot_flag, "R10 wp_n high never blocks", prot_flag, 0);
        do_read(8'h03, 24'h0000C4, 1, -1, "R10 program with wp_n high");
        wp_n = 1'b0; bp = 3'd7;
        do_wren();
        do_erase(24'h000080, 1'b0);
        chk(prot_flag, "R10 full protection blocks erase", prot_flag, 1);
        do_read(8'h03, 24'h000080, 1, -1, "R10 erase blocked content");
        wp_n = 1'b1; bp = 3'd0;

        // R6 pause in the middle of a byte, both idle levels
        mode3 = 1'b0;
        do_read(8'h03, 24'h00001E, 2, 0, "R6 resume after pause mode0");
        mode3 = 1'b1;
        do_read(8'h03, 24'h000080, 2, 1, "R6 resume after pause mode3");
        mode3 = 1'b0;
        do_read(8'h3B, 24'h0000C4, 2, 0, "R6 resume after pause dual");

        wait_clk(10);
        finish_up();
    end

endmodule